// File: doc/BRIEF.md
# Flagged Register Stack

A last-in-first-out store of 64 words held in registers. It has a 6-bit stack pointer and a full flag and an empty flag. Both flags come from the pointer itself: no separate occupancy counter exists. A push moves the pointer up by one and then writes the incoming word at the new pointer value. The 64th push therefore wraps the pointer to zero, writes location 0 and raises the full flag. A pop returns the word at the pointer and then moves the pointer down. A pop that lands on zero raises the empty flag.

The stack gives access only through push and pop; no location can be addressed directly. A push into a full stack and a pop from an empty stack are refused. Each refusal leaves all state as it was and produces a one-cycle error pulse. Asserting push and pop together is a no-op. Popped data is registered: it appears with a one-cycle valid strobe on the clock edge that accepts the pop, and it holds its value until the next accepted pop.

Top module: `flag_stack`

## Requirements
- R1: After synchronous reset the pointer is 0, empty is 1, full is 0, the error pulse is 0, the read-valid strobe is 0 and the read data is 0.
- R2: An accepted push (push=1, pop=0, full=0) advances the pointer by one modulo 64 on the next edge, stores the word and clears empty.
- R3: Full is set only by a push whose incremented pointer wraps to 0, which is the 64th push into an empty stack; whenever full is 1 the pointer is 0.
- R4: An accepted pop (pop=1, push=0, empty=0) presents the most recently pushed word that has not yet been popped on the read data output, together with a read-valid pulse, in the cycle after the request. The same edge moves the pointer down by one.
- R5: A pop that brings the pointer to 0 sets empty, and any accepted pop clears full; whenever empty is 1 the pointer is 0.
- R6: A push while full is 1 leaves the pointer, the flags and the stored words unchanged, and raises the error output for exactly one cycle.
- R7: A pop while empty is 1 leaves the pointer, the flags and the read data unchanged and gives no read-valid pulse. It raises the error output for exactly one cycle.
- R8: Push and pop asserted in the same cycle change nothing: no pointer move, no read-valid pulse, no error.
- R9: After 64 pushes the 64 pops return the words in exact reverse order, with location 0 holding the 64th word.
- R10: Full and empty are never 1 together, and the error output is 1 only in the cycle after a refused request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| wr_data_i | input | DATA_W | Word to push |
| rd_data_o | output | DATA_W | Last popped word, registered |
| rd_valid_o | output | 1 | One-cycle strobe marking a fresh popped word |
| sp_o | output | PTR_W | Current stack pointer |
| full_o | output | 1 | Stack holds 64 words |
| empty_o | output | 1 | Stack holds no word |
| err_o | output | 1 | One-cycle pulse after a refused push or pop |

## Verification
Every result of this block is due exactly one rising edge after the request that causes it. The pointer, both flags, the error pulse, the read data and its valid strobe are all registered at the edge that samples push and pop. The bench changes inputs on the falling edge and lets one rising edge pass. On the next falling edge it compares every output with a queue-based model that it advanced for that same edge. Refused and simultaneous requests are checked in the same cycle slot. Their absence of effect is checked there too, through the pointer, the flags and the held read data.

// File: rtl/flag_stack_pkg.sv
package flag_stack_pkg;

    // Request classes seen by the controller; encoding is {pop, push}
    typedef enum logic [1:0] {
        REQ_IDLE = 2'b00,
        REQ_PUSH = 2'b01,
        REQ_POP  = 2'b10,
        REQ_BOTH = 2'b11
    } req_e;

    // Decision taken for one cycle
    typedef struct packed {
        logic do_push;
        logic do_pop;
        logic refused;
    } grant_t;

    function automatic req_e classify(input logic push, input logic pop);
        return req_e'({pop, push});
    endfunction

    function automatic grant_t arbitrate(input req_e req, input logic full,
                                         input logic empty);
        grant_t g;
        g = '0;
        unique case (req)
            REQ_PUSH: begin
                g.do_push = !full;
                g.refused = full;
            end
            REQ_POP: begin
                g.do_pop  = !empty;
                g.refused = empty;
            end
            default: g = '0;   // idle or both: no operation
        endcase
        return g;
    endfunction

endpackage

// File: rtl/flag_stack_ctrl.sv
module flag_stack_ctrl
    import flag_stack_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   push_i,
    input  logic   pop_i,
    input  logic   full_i,
    input  logic   empty_i,
    output grant_t grant_o,
    output logic   err_o
);

    req_e req;

    always_comb begin
        req     = classify(push_i, pop_i);
        grant_o = arbitrate(req, full_i, empty_i);
    end

    // Refusal is reported as a registered single-cycle pulse
    always_ff @(posedge clk) begin
        if (rst) err_o <= 1'b0;
        else     err_o <= grant_o.refused;
    end

endmodule

// File: rtl/flag_stack_ptr.sv
module flag_stack_ptr #(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             do_push_i,
    input  logic             do_pop_i,
    output logic [PTR_W-1:0] sp_o,
    output logic [PTR_W-1:0] sp_up_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
    localparam logic [PTR_W-1:0] ZERO = '0;

    logic [PTR_W-1:0] sp_dn;

    always_comb begin
        sp_up_o = sp_o + ONE;
        sp_dn   = sp_o - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_o    <= ZERO;
            full_o  <= 1'b0;
            empty_o <= 1'b1;
        end else if (do_push_i) begin
            sp_o    <= sp_up_o;
            full_o  <= (sp_up_o == ZERO);
            empty_o <= 1'b0;
        end else if (do_pop_i) begin
            sp_o    <= sp_dn;
            empty_o <= (sp_dn == ZERO);
            full_o  <= 1'b0;
        end
    end

endmodule

// File: rtl/flag_stack_store.sv
module flag_stack_store #(
    parameter int PTR_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [PTR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);

    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) cells[wr_addr_i] <= wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_en_i;
            if (rd_en_i) rd_data_o <= cells[rd_addr_i];
        end
    end

endmodule

// File: rtl/flag_stack.sv
module flag_stack
    import flag_stack_pkg::*;
#(
    parameter int PTR_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic [PTR_W-1:0]  sp_o,
    output logic              full_o,
    output logic              empty_o,
    output logic              err_o
);

    grant_t           grant;
    logic [PTR_W-1:0] sp_up;

    flag_stack_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .full_i  (full_o),
        .empty_i (empty_o),
        .grant_o (grant),
        .err_o   (err_o)
    );

    flag_stack_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .do_push_i (grant.do_push),
        .do_pop_i  (grant.do_pop),
        .sp_o      (sp_o),
        .sp_up_o   (sp_up),
        .full_o    (full_o),
        .empty_o   (empty_o)
    );

    // Push writes at the incremented pointer; pop reads at the current one
    flag_stack_store #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (grant.do_push),
        .wr_addr_i  (sp_up),
        .wr_data_i  (wr_data_i),
        .rd_en_i    (grant.do_pop),
        .rd_addr_i  (sp_o),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

endmodule

// File: rtl/flag_stack_chk.sv
module flag_stack_chk #(
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             push_i,
    input logic             pop_i,
    input logic             rd_valid_o,
    input logic [PTR_W-1:0] sp_o,
    input logic             full_o,
    input logic             empty_o,
    input logic             err_o
);

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));

    assert_push_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && !full_o) |=> (sp_o == PTR_W'($past(sp_o) + 1'b1)) && !empty_o);

    assert_full_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
        full_o |-> (sp_o == '0));

    assert_pop_return_R4: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && !empty_o) |=> rd_valid_o && (sp_o == PTR_W'($past(sp_o) - 1'b1)) && !full_o);

    assert_empty_at_zero_R5: assert property (@(posedge clk) disable iff (rst)
        empty_o |-> (sp_o == '0));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && full_o) |=> err_o && full_o && $stable(sp_o));

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && empty_o) |=> err_o && empty_o && !rd_valid_o);

    assert_both_is_nop_R8: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i) |=> !err_o && !rd_valid_o && $stable(sp_o) && $stable(full_o) && $stable(empty_o));

    assert_err_single_R10: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(push_i != pop_i));

endmodule

bind flag_stack flag_stack_chk #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .rd_valid_o (rd_valid_o),
    .sp_o       (sp_o),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .err_o      (err_o)
);

// File: tb/tb_flag_stack.sv
`timescale 1ns/1ps
module tb_flag_stack;

    localparam int PTR_W  = 6;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << PTR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              push_i = 1'b0;
    logic              pop_i = 1'b0;
    logic [DATA_W-1:0] wr_data_i = '0;
    logic [DATA_W-1:0] rd_data_o;
    logic              rd_valid_o;
    logic [PTR_W-1:0]  sp_o;
    logic              full_o;
    logic              empty_o;
    logic              err_o;

    flag_stack #(.PTR_W(PTR_W), .DATA_W(DATA_W)) dut (.*);

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DATA_W-1:0] model_q[$];
    int exp_data  = 0;
    int exp_valid = 0;
    int exp_err   = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "sp", int'(sp_o), model_q.size() % DEPTH);
        check(tag, "full", int'(full_o), int'(model_q.size() == DEPTH));
        check(tag, "empty", int'(empty_o), int'(model_q.size() == 0));
        check(tag, "err", int'(err_o), exp_err);
        check(tag, "rd_valid", int'(rd_valid_o), exp_valid);
        check(tag, "rd_data", int'(rd_data_o), exp_data);
        check("R10", "flags exclusive", int'(full_o && empty_o), 0);
    endtask

    // One request cycle: drive after a falling edge, model the rising edge,
    // compare at the following falling edge.
    task automatic step(input logic p, input logic q, input logic [DATA_W-1:0] d,
                        input string tag);
        push_i    = p;
        pop_i     = q;
        wr_data_i = d;
        @(posedge clk);
        exp_err   = 0;
        exp_valid = 0;
        if (p && !q) begin
            if (model_q.size() == DEPTH) exp_err = 1;
            else model_q.push_back(d);
        end else if (q && !p) begin
            if (model_q.size() == 0) exp_err = 1;
            else begin
                exp_data  = int'(model_q.pop_back());
                exp_valid = 1;
            end
        end
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
        compare_all(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        push_i = 1'b0;
        pop_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_q.delete();
        exp_data = 0; exp_valid = 0; exp_err = 0;
        compare_all("R1");
    endtask

    initial begin
        @(negedge clk);
        do_reset();                                       // R1

        step(1, 0, 8'h11, "R2");
        step(1, 0, 8'h22, "R2");
        step(1, 0, 8'h33, "R2");
        step(0, 1, 8'h00, "R4");                          // expect 0x33
        step(1, 1, 8'hEE, "R8");                          // simultaneous: nothing
        step(0, 1, 8'h00, "R4");                          // expect 0x22
        step(0, 1, 8'h00, "R5");                          // expect 0x11, empty
        step(0, 1, 8'h00, "R7");                          // refused pop
        step(0, 0, 8'h00, "R7");                          // error gone, data held

        for (int i = 0; i < DEPTH; i++)
            step(1, 0, 8'(i * 3 + 7), (i == DEPTH - 1) ? "R3" : "R2");
        step(1, 0, 8'hAB, "R6");                          // refused push
        step(0, 0, 8'h00, "R6");
        step(1, 1, 8'hCD, "R8");
        for (int i = 0; i < DEPTH; i++)
            step(0, 1, 8'h00, (i == DEPTH - 1) ? "R5" : "R9");
        step(0, 1, 8'h00, "R7");

        // interleaved pattern
        for (int i = 0; i < 5; i++) step(1, 0, 8'(8'h40 + i), "R2");
        step(0, 1, 8'h00, "R4");
        step(1, 0, 8'h90, "R2");
        step(1, 0, 8'h91, "R2");
        for (int i = 0; i < 6; i++) step(0, 1, 8'h00, "R4");
        step(0, 1, 8'h00, "R7");

        // reset from a partly filled stack
        step(1, 0, 8'h5A, "R2");
        step(1, 0, 8'h5B, "R2");
        do_reset();                                       // R1
        step(0, 1, 8'h00, "R7");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule